// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block is the byte-wide register front end for a three-channel programmable interval timer. The host reaches it through a 2-bit address. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2, and address 3 is a write-only control port. Control words set, for each channel, how bytes are transferred (low byte only, high byte only, or low byte then high byte), the counting mode and a BCD flag. Control words can also freeze a channel's count for a clean read. A read-back form of the control word can freeze the count, a status byte, or both, on several channels in one write.

The counting elements are outside this block. The front end sends each one a one-cycle load strobe with a 16-bit value, together with its counting mode and BCD flag. It takes back each channel's live count, its OUT level, and an acknowledge that the loaded count has entered the counter.

Top module: `pit_regif`

## Requirements
- R1: A read at address 3 returns 0x00 and changes no state.
- R2: A control word (address 3) with bits 7:6 = channel n (0..2) and bits 5:4 non-zero stores bits 5:4 as the access mode (1 low only, 2 high only, 3 low then high), bits 3:1 as the counting mode and bit 0 as BCD, and puts both byte pointers of channel n back to "low byte next". The counting mode appears on `cnt_mode[3n+2:3n]` and BCD on `cnt_bcd[n]` from the next cycle on.
- R3: In access mode 1, a data write of byte b to channel n raises `load_stb[n]` for exactly one cycle, in the cycle after the write, with `load_val[16n+15:16n]` = {0x00, b}.
- R4: In access mode 2, a data write of byte b gives a load of {b, 0x00}, with the same timing as R3.
- R5: In access mode 3, the first data write is held and produces no load. The second write loads {second, first}, and the pointer then expects a low byte again.
- R6: A control word with bits 5:4 = 0 freezes channel n's live count in the cycle of the write. The request is ignored while a frozen count of that channel is still unread.
- R7: A frozen count is read according to the access mode: mode 1 gives the low byte, mode 2 the high byte, and mode 3 the low byte then the high byte. The freeze is released after the final byte.
- R8: A read-back command (bits 7:6 = 3) applies to channel n when bit n+1 is 1. Bit 5 = 0 freezes the count, following the rule of R6. Bit 4 = 0 captures a status byte, unless a status byte of that channel is still unread, in which case the held byte is kept.
- R9: The status byte is {OUT level, null count, access mode[1:0], counting mode[2:0], BCD}, from bit 7 down to bit 0, with the OUT level taken in the command cycle.
- R10: A data read returns the pending status first, then the frozen count, then the live count. Each read consumes what it returns. Live reads in access mode 3 alternate low byte and high byte.
- R11: The null-count flag of a channel is set when a load strobe is issued and cleared by `load_ack[n]`. When both happen in the same cycle, the set wins.
- R12: After reset every channel has access mode 3, counting mode 0, binary counting, no frozen count, no pending status and null count clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Port select: 0..2 channel data, 3 control |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte, valid in the cycle of `rd_en` |
| load_stb | output | 3 | One-cycle count load strobe per channel |
| load_val | output | 48 | Count load value, 16 bits per channel |
| cnt_mode | output | 9 | Counting mode, 3 bits per channel |
| cnt_bcd | output | 3 | BCD flag per channel |
| live_cnt | input | 48 | Live count from each counter, 16 bits per channel |
| out_lvl | input | 3 | OUT level of each counter |
| load_ack | input | 3 | Counter has taken the loaded count |

## Verification
`rdata` is combinational, so the byte is checked in the same cycle as `rd_en`, just after the inputs settle. The pointer and latch side effects of that read appear at the following edge, and the next read shows them. A data write becomes a load strobe one edge later. The bench therefore compares `load_stb`, `load_val`, `cnt_mode` and `cnt_bcd` at the falling edge after every rising edge, against values its model predicted for that cycle. Frozen counts and status bytes are predicted from the live count, OUT level and null-count flag present in the command cycle. The null-count flag is therefore seen only through status bytes read later.

// File: rtl/pit_regif.sv
module pit_regif (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [2:0]  load_stb,
  output logic [47:0] load_val,
  output logic [8:0]  cnt_mode,
  output logic [2:0]  cnt_bcd,
  input  logic [47:0] live_cnt,
  input  logic [2:0]  out_lvl,
  input  logic [2:0]  load_ack
);
  logic [2:0][1:0]  acc;
  logic [2:0][2:0]  mode;
  logic [2:0]       bcd, wptr, rptr, st_pend, nullc;
  logic [2:0][7:0]  wlat, st_byte;
  logic [2:0][15:0] lcnt, lv, live, dval;
  logic [2:0][1:0]  lst;
  logic [2:0]       lreq, sreq, mset, dload;
  logic [1:0]       ci;

  wire ctrl = wr_en && addr == 2'd3;
  wire rb   = wdata[7:6] == 2'd3;

  assign live     = live_cnt;
  assign load_val = lv;
  assign cnt_mode = mode;
  assign cnt_bcd  = bcd;
  assign ci       = (addr == 2'd3) ? 2'd0 : addr;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      lreq[i] = ctrl && ((!rb && wdata[7:6] == 2'(i) && wdata[5:4] == 2'd0) ||
                         (rb && wdata[i+1] && !wdata[5]));
      sreq[i] = ctrl && rb && wdata[i+1] && !wdata[4];
      mset[i] = ctrl && !rb && wdata[7:6] == 2'(i) && wdata[5:4] != 2'd0;
      dload[i] = 1'b0;
      dval[i]  = 16'h0;
      if (wr_en && addr == 2'(i)) begin
        case (acc[i])
          2'd1: begin dload[i] = 1'b1;    dval[i] = {8'h00, wdata}; end
          2'd2: begin dload[i] = 1'b1;    dval[i] = {wdata, 8'h00}; end
          2'd3: begin dload[i] = wptr[i]; dval[i] = {wdata, wlat[i]}; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr != 2'd3) begin
      if (st_pend[ci])
        rdata = st_byte[ci];
      else if (lst[ci] != 2'd0)
        rdata = (lst[ci] == 2'd2) ? lcnt[ci][15:8] : lcnt[ci][7:0];
      else if (acc[ci] == 2'd2 || (acc[ci] == 2'd3 && rptr[ci]))
        rdata = live[ci][15:8];
      else
        rdata = live[ci][7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        acc[i] <= 2'd3; mode[i] <= 3'd0; lst[i] <= 2'd0;
        lcnt[i] <= 16'h0; lv[i] <= 16'h0; wlat[i] <= 8'h0; st_byte[i] <= 8'h0;
      end
      bcd <= '0; wptr <= '0; rptr <= '0; st_pend <= '0; nullc <= '0; load_stb <= '0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        load_stb[i] <= dload[i];
        if (dload[i]) lv[i] <= dval[i];
        if (dload[i]) nullc[i] <= 1'b1;
        else if (load_ack[i]) nullc[i] <= 1'b0;

        if (wr_en && addr == 2'(i) && acc[i] == 2'd3) begin
          if (!wptr[i]) wlat[i] <= wdata;
          wptr[i] <= ~wptr[i];
        end

        if (rd_en && addr == 2'(i)) begin
          if (st_pend[i])
            st_pend[i] <= 1'b0;
          else if (lst[i] != 2'd0)
            lst[i] <= (lst[i] == 2'd3) ? 2'd2 : 2'd0;
          else if (acc[i] == 2'd3)
            rptr[i] <= ~rptr[i];
        end

        if (lreq[i] && lst[i] == 2'd0) begin
          lcnt[i] <= live[i];
          lst[i]  <= acc[i];
        end
        if (sreq[i] && !st_pend[i]) begin
          st_byte[i] <= {out_lvl[i], nullc[i], acc[i], mode[i], bcd[i]};
          st_pend[i] <= 1'b1;
        end
        if (mset[i]) begin
          acc[i]  <= wdata[5:4];
          mode[i] <= wdata[3:1];
          bcd[i]  <= wdata[0];
          wptr[i] <= 1'b0;
          rptr[i] <= 1'b0;
        end
      end
    end
  end
endmodule

module pit_regif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  rdata,
  input logic [2:0]  load_stb,
  input logic [47:0] load_val,
  input logic [5:0]  acc,
  input logic [2:0]  nullc
);
  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 2'd3 |-> rdata == 8'h00); // R1
  AST_ONE_LOAD_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb)); // R3
  AST_LOAD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    |load_stb |-> $past(wr_en && addr != 2'd3)); // R5
  AST_LOW_ONLY_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb[0] && $past(acc[1:0]) == 2'd1 |-> load_val[15:8] == 8'h00); // R3
  AST_HIGH_ONLY_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb[2] && $past(acc[5:4]) == 2'd2 |-> load_val[39:32] == 8'h00); // R4
  AST_NULL_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb[1] |-> nullc[1]); // R11
endmodule

bind pit_regif pit_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .load_stb(load_stb), .load_val(load_val), .acc(acc), .nullc(nullc)
);

// File: tb/pit_regif_bench.sv
`timescale 1ns/1ps
module pit_regif_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic [2:0] load_stb, out_lvl = 0, load_ack = 0;
  logic [47:0] load_val, live_cnt = 0;
  logic [8:0] cnt_mode;
  logic [2:0] cnt_bcd;

  always #2.5 clk = ~clk;

  pit_regif u_pit_regif (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .load_stb(load_stb), .load_val(load_val), .cnt_mode(cnt_mode),
    .cnt_bcd(cnt_bcd), .live_cnt(live_cnt), .out_lvl(out_lvl), .load_ack(load_ack));

  int runs = 0, fails = 0, tick = 0;
  bit done = 0;
  int m_acc[3], m_mode[3], m_bcd[3], m_wptr[3], m_rptr[3], m_wlat[3];
  int m_lcnt[3], m_lst[3], m_stp[3], m_stb[3], m_null[3];
  int e_stb[3], e_val[3];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int livev(input int i);
    return int'(live_cnt[16*i +: 16]);
  endfunction

  task automatic m_latch(input int i);
    if (m_lst[i] == 0) begin m_lcnt[i] = livev(i); m_lst[i] = m_acc[i]; end
  endtask

  task automatic m_write(input int a, input int d);
    if (a == 3) begin
      int ch = (d >> 6) & 3;
      if (ch == 3) begin
        for (int i = 0; i < 3; i++) if (d & (2 << i)) begin
          if (!(d & 32)) m_latch(i);
          if (!(d & 16) && !m_stp[i]) begin
            m_stb[i] = (int'(out_lvl[i]) << 7) | (m_null[i] << 6) | (m_acc[i] << 4) | (m_mode[i] << 1) | m_bcd[i];
            m_stp[i] = 1;
          end
        end
      end else if (((d >> 4) & 3) == 0) m_latch(ch);
      else begin
        m_acc[ch] = (d >> 4) & 3; m_mode[ch] = (d >> 1) & 7; m_bcd[ch] = d & 1;
        m_wptr[ch] = 0; m_rptr[ch] = 0;
      end
    end else begin
      if (m_acc[a] == 1) begin e_stb[a] = 1; e_val[a] = d; end
      else if (m_acc[a] == 2) begin e_stb[a] = 1; e_val[a] = d << 8; end
      else if (m_wptr[a] == 0) begin m_wlat[a] = d; m_wptr[a] = 1; end
      else begin e_stb[a] = 1; e_val[a] = (d << 8) | m_wlat[a]; m_wptr[a] = 0; end
      if (e_stb[a]) m_null[a] = 1;
    end
  endtask

  task automatic m_read(input int a, output int v);
    if (a == 3) v = 0;
    else if (m_stp[a]) begin v = m_stb[a]; m_stp[a] = 0; end
    else if (m_lst[a] == 1) begin v = m_lcnt[a] & 255; m_lst[a] = 0; end
    else if (m_lst[a] == 2) begin v = m_lcnt[a] >> 8; m_lst[a] = 0; end
    else if (m_lst[a] == 3) begin v = m_lcnt[a] & 255; m_lst[a] = 2; end
    else if (m_acc[a] == 1) v = livev(a) & 255;
    else if (m_acc[a] == 2) v = livev(a) >> 8;
    else begin v = m_rptr[a] ? (livev(a) >> 8) : (livev(a) & 255); m_rptr[a] ^= 1; end
  endtask

  // kind: 0 idle, 1 write, 2 read
  task automatic step(input int kind, input int a, input int d, input int ack, input string tag);
    int v;
    tick++;
    live_cnt = {16'(tick * 911 + 7), 16'(16'hA5C3 - tick * 3), 16'(tick * 257 + 16'h0F1E)};
    out_lvl  = 3'(tick);
    addr = 2'(a); wdata = 8'(d); wr_en = (kind == 1); rd_en = (kind == 2); load_ack = 3'(ack);
    for (int i = 0; i < 3; i++) e_stb[i] = 0;
    #1;
    if (kind == 2) begin
      m_read(a, v);
      chk(int'(rdata) == v, tag, int'(rdata), v);
    end
    if (kind == 1) m_write(a, d);
    for (int i = 0; i < 3; i++) if (ack[i] && !e_stb[i]) m_null[i] = 0;
    @(posedge clk); @(negedge clk);
    wr_en = 0; rd_en = 0; load_ack = 0;
    for (int i = 0; i < 3; i++) begin
      chk(int'(load_stb[i]) == e_stb[i], tag, int'(load_stb[i]), e_stb[i]);
      if (e_stb[i]) chk(int'(load_val[16*i +: 16]) == e_val[i], tag, int'(load_val[16*i +: 16]), e_val[i]);
      chk(int'(cnt_mode[3*i +: 3]) == m_mode[i], "R2", int'(cnt_mode[3*i +: 3]), m_mode[i]);
      chk(int'(cnt_bcd[i]) == m_bcd[i], "R2", int'(cnt_bcd[i]), m_bcd[i]);
    end
  endtask

  task automatic rd(input int a, input string tag); step(2, a, 0, 0, tag); endtask
  task automatic wr(input int a, input int d, input string tag); step(1, a, d, 0, tag); endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_acc[i] = 3; m_mode[i] = 0; m_bcd[i] = 0; m_wptr[i] = 0; m_rptr[i] = 0; m_wlat[i] = 0;
      m_lcnt[i] = 0; m_lst[i] = 0; m_stp[i] = 0; m_stb[i] = 0; m_null[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 0, "R12");
    wr(3, 8'hEE, "R12");
    rd(0, "R9"); rd(1, "R9"); rd(2, "R9");
    rd(0, "R12"); rd(0, "R10"); rd(0, "R10");
    rd(3, "R1"); rd(3, "R1");
    wr(0, 8'h34, "R5"); wr(0, 8'h12, "R5"); wr(0, 8'h99, "R5"); wr(0, 8'h77, "R5");
    wr(3, 8'h54, "R2"); wr(1, 8'hAB, "R3"); wr(1, 8'h00, "R3");
    wr(3, 8'hA7, "R2"); wr(2, 8'hCD, "R4");
    wr(3, 8'h00, "R6"); step(0, 0, 0, 0, "R6"); wr(3, 8'h00, "R6");
    rd(0, "R7"); rd(0, "R7"); rd(0, "R10"); rd(0, "R10");
    wr(3, 8'hC4, "R8"); wr(3, 8'hD4, "R8");
    rd(1, "R10"); rd(1, "R10"); rd(1, "R10");
    wr(3, 8'hE2, "R11"); rd(0, "R11");
    step(0, 0, 0, 1, "R11");
    wr(3, 8'hE2, "R11"); rd(0, "R11");
    wr(3, 8'h14, "R11");
    step(1, 0, 8'h5A, 1, "R11");
    wr(3, 8'hE2, "R11"); rd(0, "R11");
    wr(3, 8'hB0, "R2"); wr(2, 8'h11, "R2"); wr(3, 8'hB2, "R2");
    wr(2, 8'h22, "R5"); wr(2, 8'h33, "R5");
    wr(3, 8'hA0, "R2"); wr(3, 8'h80, "R7"); rd(2, "R7"); rd(2, "R10");
    wr(3, 8'hD8, "R8"); wr(3, 8'hF8, "R8"); rd(2, "R8"); rd(2, "R8");
    wr(3, 8'hCE, "R8"); rd(0, "R9"); rd(1, "R9"); rd(2, "R9");
    rd(0, "R7"); rd(1, "R7"); rd(2, "R7"); rd(3, "R1"); rd(0, "R10");
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      runs++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule